// File: doc/BRIEF.md
# Configurable Interrupt Controller Slice

This block gathers 32 asynchronous interrupt request lines and turns them into two processor-facing requests: a normal interrupt output and a fast interrupt output. Each line is resynchronised to the slice clock and then conditioned. Each line has its own setting for the active sense (high or low), for level or edge detection, and for which of the two outputs it drives.

Software sees the slice through a simple word-wide register bus made of a byte address, a write strobe, write data and combinational read data. There are six word registers: the per-line enable mask, the raw status, the masked status, the active-sense bits, the detection-mode bits and the output-routing bits. Edge events are held in sticky status bits until software clears them through the raw status word. Several slices can sit side by side. Software then picks the slice from the upper bits of a line number and the bit position from the lower five bits.

Top module: `irq_slice`

## Requirements
- R1: After reset the enable, sense, mode and routing words all read 0, both request outputs are low, and no edge event is held.
- R2: Writing a word at byte offset 0 (enable), 12 (sense), 16 (mode) or 20 (routing) stores it, and reading the same offset returns it. Offset 4 reads the raw status, offset 8 reads the masked status, and any other offset reads 0.
- R3: A line in level mode (mode bit 0) shows in the raw status word as its conditioned input: the pin value itself when its sense bit is 1, the inverted pin when the sense bit is 0. A pin change is visible in the raw status at the second rising clock edge after the change.
- R4: A line in edge mode (mode bit 1) sets its raw status bit at the third rising edge after an active edge on the pin. The active edge is rising when the sense bit is 1 and falling when it is 0. The bit stays set after the pin goes back. An edge in the other direction sets nothing.
- R5: Writing a 1 to a bit at offset 4 clears the held event of an edge-mode line. Bits written as 0 are unchanged. Writes to bits of level-mode lines have no effect on the raw status.
- R6: The masked status word equals the raw status ANDed with the enable word.
- R7: The normal output is the registered OR of the masked bits whose routing bit is 0. The fast output is the registered OR of the masked bits whose routing bit is 1. Each output changes one rising edge after the masked status does.
- R8: Writes to offset 8 and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 32 | Asynchronous interrupt request pins |
| busAddr | input | 5 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Combined normal interrupt request |
| fiqOut | output | 1 | Combined fast interrupt request |

## Verification
The assertions assume that the bus address and write strobe are known values from the first clock edge onward. They also assume that a change to a line's mode or sense bit is not counted as an edge event by the checks that watch held bits. The stimulus drives every bus and pin input from time zero and changes inputs only on falling clock edges. Before it switches any line into edge mode, it writes the sense word and waits until the synchroniser has settled, so no reconfiguration creates an edge that is not wanted.

// File: rtl/irq_slice_pkg.sv
package irq_slice_pkg;

  localparam int unsigned WORD_IDX_ENABLE = 0;
  localparam int unsigned WORD_IDX_RAW    = 1;
  localparam int unsigned WORD_IDX_MASKED = 2;
  localparam int unsigned WORD_IDX_SENSE  = 3;
  localparam int unsigned WORD_IDX_MODE   = 4;
  localparam int unsigned WORD_IDX_ROUTE  = 5;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED,
    SEL_SENSE,
    SEL_MODE,
    SEL_ROUTE,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrSense;
    logic   wrMode;
    logic   wrRoute;
    logic   clrEvent;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_slice_sync.sv
module irq_slice_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/irq_slice_ctrl.sv
module irq_slice_ctrl
  import irq_slice_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  rdSel_e           sel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(WORD_IDX_ENABLE): sel = SEL_ENABLE;
        IDX_W'(WORD_IDX_RAW):    sel = SEL_RAW;
        IDX_W'(WORD_IDX_MASKED): sel = SEL_MASKED;
        IDX_W'(WORD_IDX_SENSE):  sel = SEL_SENSE;
        IDX_W'(WORD_IDX_MODE):   sel = SEL_MODE;
        IDX_W'(WORD_IDX_ROUTE):  sel = SEL_ROUTE;
        default:                 sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.rdSel    = sel;
    strobe.wrEnable = busWrEn && (sel == SEL_ENABLE);
    strobe.wrSense  = busWrEn && (sel == SEL_SENSE);
    strobe.wrMode   = busWrEn && (sel == SEL_MODE);
    strobe.wrRoute  = busWrEn && (sel == SEL_ROUTE);
    strobe.clrEvent = busWrEn && (sel == SEL_RAW);
  end

endmodule

// File: rtl/irq_slice_dp.sv
module irq_slice_dp
  import irq_slice_pkg::*;
#(
  parameter int unsigned LINES       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] wrData,
  input  ctrlStrobe_t      strobe,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] enableReg,
  output logic [LINES-1:0] modeReg,
  output logic [LINES-1:0] routeReg,
  output logic [LINES-1:0] rawStatus,
  output logic [LINES-1:0] maskedStatus,
  output logic             irqOut,
  output logic             fiqOut
);

  logic [LINES-1:0] senseReg;
  logic [LINES-1:0] syncLine;
  logic [LINES-1:0] condNow;
  logic [LINES-1:0] condPrev;
  logic [LINES-1:0] edgeHit;
  logic [LINES-1:0] eventHeld;
  logic [LINES-1:0] eventNext;
  logic [LINES-1:0] clrMask;
  logic             irqQ;
  logic             fiqQ;

  irq_slice_sync #(
    .WIDTH (LINES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(lineIn),
    .syncOut(syncLine)
  );

  // Sense 1 passes the pin, sense 0 inverts it.
  assign condNow = ~(syncLine ^ senseReg);
  assign edgeHit = condNow & ~condPrev;
  assign clrMask = strobe.clrEvent ? wrData : '0;

  // A new edge wins over a clear in the same cycle; level lines hold nothing.
  assign eventNext = ((eventHeld & ~clrMask) | edgeHit) & modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      senseReg  <= '0;
      modeReg   <= '0;
      routeReg  <= '0;
      condPrev  <= '0;
      eventHeld <= '0;
    end else begin
      if (strobe.wrEnable) enableReg <= wrData;
      if (strobe.wrSense)  senseReg  <= wrData;
      if (strobe.wrMode)   modeReg   <= wrData;
      if (strobe.wrRoute)  routeReg  <= wrData;
      condPrev  <= condNow;
      eventHeld <= eventNext;
    end
  end

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign rawStatus[i] = modeReg[i] ? eventHeld[i] : condNow[i];
    end
  endgenerate

  assign maskedStatus = rawStatus & enableReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
      fiqQ <= 1'b0;
    end else begin
      irqQ <= |(maskedStatus & ~routeReg);
      fiqQ <= |(maskedStatus & routeReg);
    end
  end

  assign irqOut = irqQ;
  assign fiqOut = fiqQ;

  always_comb begin
    case (strobe.rdSel)
      SEL_ENABLE: rdData = enableReg;
      SEL_RAW:    rdData = rawStatus;
      SEL_MASKED: rdData = maskedStatus;
      SEL_SENSE:  rdData = senseReg;
      SEL_MODE:   rdData = modeReg;
      SEL_ROUTE:  rdData = routeReg;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_slice.sv
module irq_slice
  import irq_slice_pkg::*;
#(
  parameter int unsigned LINES       = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [LINES-1:0]  busWrData,
  output logic [LINES-1:0]  busRdData,
  output logic              irqOut,
  output logic              fiqOut
);

  ctrlStrobe_t      strobe;
  logic [LINES-1:0] enableReg;
  logic [LINES-1:0] modeReg;
  logic [LINES-1:0] routeReg;
  logic [LINES-1:0] rawStatus;
  logic [LINES-1:0] maskedStatus;

  irq_slice_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  irq_slice_dp #(
    .LINES      (LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .wrData      (busWrData),
    .strobe      (strobe),
    .rdData      (busRdData),
    .enableReg   (enableReg),
    .modeReg     (modeReg),
    .routeReg    (routeReg),
    .rawStatus   (rawStatus),
    .maskedStatus(maskedStatus),
    .irqOut      (irqOut),
    .fiqOut      (fiqOut)
  );

endmodule

// File: rtl/irq_slice_chk.sv
module irq_slice_chk #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [LINES-1:0]  enableReg,
  input logic [LINES-1:0]  modeReg,
  input logic [LINES-1:0]  routeReg,
  input logic [LINES-1:0]  rawStatus,
  input logic [LINES-1:0]  maskedStatus,
  input logic              irqOut,
  input logic              fiqOut
);

  logic clrWrite;
  assign clrWrite = busWrEn && (busAddr == ADDR_W'(4));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (enableReg == '0 && modeReg == '0 && routeReg == '0 && !irqOut && !fiqOut));

  p_event_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrWrite) |-> ((($past(rawStatus) & $past(modeReg) & modeReg) & ~rawStatus) == '0));

  p_masked_subset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~enableReg) == '0);

  p_irq_needs_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(enableReg & ~routeReg) != '0));

  p_fiq_needs_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> ($past(enableReg & routeReg) != '0));

endmodule

bind irq_slice irq_slice_chk #(
  .LINES (LINES),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .enableReg   (enableReg),
  .modeReg     (modeReg),
  .routeReg    (routeReg),
  .rawStatus   (rawStatus),
  .maskedStatus(maskedStatus),
  .irqOut      (irqOut),
  .fiqOut      (fiqOut)
);

// File: tb/irq_slice_bench.sv
`timescale 1ns/1ps
module irq_slice_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lineIn = '1;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;
  logic        fiqOut;

  int total = 0;
  int bad = 0;
  bit summaryDone = 1'b0;

  // Bench model of the configuration and held events
  logic [31:0] enM = '0, senseM = '0, modeM = '0, routeM = '0, heldM = '0;

  always #10 clk = ~clk;

  irq_slice u_irq_slice (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1;
    data = busRdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLines(input logic [31:0] v);
    @(negedge clk);
    lineIn = v;
  endtask

  function automatic logic [31:0] expRaw();
    logic [31:0] cond;
    cond = ~(lineIn ^ senseM);
    return (cond & ~modeM) | (heldM & modeM);
  endfunction

  task automatic testReset();
    logic [31:0] d;
    waitN(3);
    busRead(5'd0, d);  check("R1 enable", d, 32'h0);
    busRead(5'd12, d); check("R1 sense", d, 32'h0);
    busRead(5'd16, d); check("R1 mode", d, 32'h0);
    busRead(5'd20, d); check("R1 route", d, 32'h0);
    busRead(5'd4, d);  check("R1 raw", d, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 fiq", {31'b0, fiqOut}, 32'h0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    busWrite(5'd0, 32'hA5A5_0F0F);  busRead(5'd0, d);  check("R2 enable", d, 32'hA5A5_0F0F);
    busWrite(5'd16, 32'h1357_9BDF); busRead(5'd16, d); check("R2 mode", d, 32'h1357_9BDF);
    busWrite(5'd20, 32'hDEAD_BEEF); busRead(5'd20, d); check("R2 route", d, 32'hDEAD_BEEF);
    busWrite(5'd12, 32'h0000_FFFF); busRead(5'd12, d); check("R2 sense", d, 32'h0000_FFFF);
    busRead(5'd24, d); check("R2 unmapped read", d, 32'h0);
    busWrite(5'd8, 32'hFFFF_FFFF);
    busRead(5'd0, d); check("R8 masked write ignored", d, 32'hA5A5_0F0F);
    busWrite(5'd24, 32'hFFFF_FFFF);
    busRead(5'd20, d); check("R8 unmapped write ignored", d, 32'hDEAD_BEEF);
    busWrite(5'd0, 32'h0);  enM = 32'h0;
    busWrite(5'd16, 32'h0); modeM = 32'h0;
    busWrite(5'd20, 32'h0); routeM = 32'h0;
    senseM = 32'h0000_FFFF;
  endtask

  task automatic testLevel();
    logic [31:0] d;
    setLines(32'h1234_00F0); waitN(2);
    busRead(5'd4, d); check("R3 level pattern A", d, expRaw());
    setLines(32'hFFFF_0000); waitN(2);
    busRead(5'd4, d); check("R3 level all inactive", d, expRaw());
    setLines(32'h0000_FFFF); waitN(1);
    busRead(5'd4, d); check("R3 not yet after one edge", d, 32'h0);
    waitN(1);
    busRead(5'd4, d); check("R3 all active", d, 32'hFFFF_FFFF);
  endtask

  task automatic testMask();
    logic [31:0] d;
    busWrite(5'd0, 32'h00FF_00FF);  enM = 32'h00FF_00FF;
    busWrite(5'd20, 32'h0F0F_0F0F); routeM = 32'h0F0F_0F0F;
    setLines(32'h5A5A_C3C3); waitN(3);
    busRead(5'd8, d); check("R6 masked pattern A", d, expRaw() & enM);
    check("R7 irq pattern A", {31'b0, irqOut}, {31'b0, |(expRaw() & enM & ~routeM)});
    check("R7 fiq pattern A", {31'b0, fiqOut}, {31'b0, |(expRaw() & enM & routeM)});
    setLines(32'hFFFF_0000); waitN(3);
    busRead(5'd8, d); check("R6 masked none", d, 32'h0);
    check("R7 irq none", {31'b0, irqOut}, 32'h0);
    check("R7 fiq none", {31'b0, fiqOut}, 32'h0);
    setLines(32'hFFFF_0001); waitN(3);
    check("R7 fiq only", {30'b0, irqOut, fiqOut}, 32'h1);
    setLines(32'hFFFF_0010); waitN(2);
    busRead(5'd8, d); check("R6 masked bit4", d, 32'h0000_0010);
    check("R7 irq not yet registered", {31'b0, irqOut}, 32'h0);
    waitN(1);
    check("R7 irq only", {30'b0, irqOut, fiqOut}, 32'h2);
  endtask

  task automatic testEdge();
    logic [31:0] d;
    setLines(32'hFFBF_0000); waitN(4);
    busWrite(5'd16, 32'hFFFF_0008); modeM = 32'hFFFF_0008;
    waitN(2);
    busRead(5'd4, d); check("R4 no event before edge", d, expRaw());
    setLines(32'hFFEF_0008); waitN(1);
    setLines(32'hFFFF_0000); waitN(4);
    heldM = 32'h0010_0008;
    busRead(5'd4, d); check("R4 events held after return", d, expRaw());
    check("R4 R7 irq from held bit20", {31'b0, irqOut}, 32'h1);
    check("R4 R7 fiq from held bit3", {31'b0, fiqOut}, 32'h1);
  endtask

  task automatic testClear();
    logic [31:0] d;
    busWrite(5'd4, 32'h0010_FFF0);
    heldM = 32'h0000_0008;
    busRead(5'd4, d); check("R5 clear bit20 keep bit3 and level bits", d, expRaw());
    waitN(1);
    check("R5 irq drops after clear", {30'b0, irqOut, fiqOut}, 32'h1);
    busWrite(5'd4, 32'h0000_0008);
    heldM = 32'h0;
    busRead(5'd4, d); check("R5 clear bit3", d, expRaw());
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    waitN(5);
    rstN = 1'b1;
    testReset();
    testRegs();
    testLevel();
    testMask();
    testEdge();
    testClear();
    finishRun();
  end

endmodule